// File: doc/BRIEF.md
# Selectable-Mode Rounding Stage

This block sits behind an accumulator and narrows a wide two's-complement value. Each sample comes with a shift amount `s`. The shift says how many low bits to discard. The result is the value divided by 2^s and rounded. It is still presented at the full input width, sign-extended.

Every rounding method uses the same datapath. A bias constant is added to the value, and the sum is then shifted arithmetically right by `s`. A mode select chooses the method for each sample. The bias is worked out per sample from four things:

- the mode,
- the sign of the value,
- the discarded bits,
- the lowest retained bit.

The bias never has a bit set at or above position `s`.

The sum is formed one bit wider than the input, so the rounded result always fits the output width and no saturation is needed. The result is registered, giving one cycle of latency. The input width must be a power of two, and the shift amount is `$clog2(IN_W)` bits wide.

Top module: `round_stage`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `out_data` changes only then; with `in_valid` low, `out_data` holds its previous value.
- R2: While `rst_n` is low at a clock edge, `out_valid` and `out_data` become 0.
- R3: Mode code 0 (toward zero): the result is the quotient value/2^s truncated toward zero. The bias is all ones in the `s` low bits for negative inputs and 0 otherwise.
- R4: Mode code 1 (toward infinity): the result is rounded to nearest, with exact halves going away from zero.
- R5: Mode code 4 (convergent): the result is rounded to nearest, with exact halves going to the even neighbour.
- R6: Mode code 2 (dynamic): the bias is the low `s` bits of `dyn_bias` sampled with the value. The result is floor((value + bias)/2^s).
- R7: Mode code 3 (random): the bias is the low `s` bits of a 16-bit LFSR state. The LFSR update is `next = {st[0], st[15:1]} ^ (st[0] ? 16'h3400 : 0)`. The LFSR advances once on every valid sample in any mode. The sample uses the state from before that advance. At reset the LFSR loads `lfsr_seed`, and a zero seed is replaced by 1.
- R8: With `s` = 0 the output equals the input in every mode.
- R9: Mode codes 5, 6 and 7 add no bias, so the result is floor(value/2^s).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the LFSR seed |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Two's-complement value to round |
| in_shift | input | $clog2(IN_W) | Number of low bits to discard |
| in_mode | input | 3 | Rounding method code (see R3 to R9) |
| dyn_bias | input | IN_W | Run-time bias for dynamic mode |
| lfsr_seed | input | 16 | LFSR load value, taken at reset |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_data | output | IN_W | Rounded, sign-extended result |

## Verification
The bench is built at an 8-bit width. It sweeps every input value against every shift amount in every mode, reserved codes included. This reaches the exact-half ties, where a toward-infinity stage with a single constant would send negative halves toward plus infinity, and a convergent stage without the retained-bit term would round 2.5 up to 3. The sweep also reaches the extremes at the largest shift, where an adder only as wide as the input would wrap 127 plus its bias into a negative result. Zero shift is covered as well: here a bias of half-minus-one would underflow and corrupt values that must pass through unchanged. For random mode, a reference LFSR in the bench advances on samples of every mode, so an LFSR that stepped only in random mode, stepped on idle cycles, or used its post-step state would produce wrong results. A reset with a zero seed checks that the generator does not lock up.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  localparam int LFSR_W = 16;

  typedef enum logic [2:0] {
    RM_ZERO = 3'd0,
    RM_INF  = 3'd1,
    RM_DYN  = 3'd2,
    RM_RAND = 3'd3,
    RM_EVEN = 3'd4
  } rnd_mode_e;

  // Galois right-shift step, feedback mask for x^16+x^14+x^13+x^11+1
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] st);
    logic [LFSR_W-1:0] nx;
    nx = st >> 1;
    if (st[0]) nx = nx ^ 16'hB400;
    return nx;
  endfunction

endpackage

// File: rtl/rnd_lfsr.sv
module rnd_lfsr
  import rnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LFSR_W-1:0] seed,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);

  logic [LFSR_W-1:0] seed_safe;
  assign seed_safe = (seed == '0) ? LFSR_W'(1) : seed;

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= seed_safe;
    else if (step) state <= lfsr_next(state);
  end

  // R7: the generator never locks into the all-zero state
  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R7: the state moves only on valid samples
  assert_lfsr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));

endmodule

// File: rtl/rnd_bias.sv
module rnd_bias
  import rnd_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [SW-1:0] shift,
  input  logic [2:0]    mode,
  input  logic [W-1:0]  dyn,
  input  logic [W-1:0]  rnd,
  output logic [W-1:0]  bias,
  output logic          tie
);

  function automatic logic [W-1:0] low_mask(input logic [SW-1:0] s);
    return ~({W{1'b1}} << s);
  endfunction

  function automatic logic [W-1:0] half_lsb(input logic [SW-1:0] s);
    return (W'(1) << s) >> 1;
  endfunction

  logic [W-1:0] mask, half;
  logic         neg, keep_lsb, zero_sh;

  assign mask     = low_mask(shift);
  assign half     = half_lsb(shift);
  assign neg      = data[W-1];
  assign keep_lsb = data[shift];
  assign zero_sh  = (shift == '0);
  assign tie      = !zero_sh && ((data & mask) == half);

  always_comb begin
    case (mode)
      RM_ZERO: bias = neg ? mask : '0;
      RM_INF:  bias = zero_sh ? '0 : (neg ? half - W'(1) : half);
      RM_EVEN: bias = zero_sh ? '0 : half - W'(1) + W'(keep_lsb);
      RM_DYN:  bias = dyn & mask;
      RM_RAND: bias = rnd & mask;
      default: bias = '0;
    endcase
  end

endmodule

// File: rtl/rnd_sum.sv
module rnd_sum #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [W-1:0]  bias,
  input  logic [SW-1:0] shift,
  output logic [W-1:0]  result
);

  function automatic logic [W-1:0] add_shift(input logic [W-1:0] x,
                                             input logic [W-1:0] b,
                                             input logic [SW-1:0] s);
    logic signed [W:0] sum;
    logic signed [W:0] sh;
    sum = $signed({x[W-1], x}) + $signed({1'b0, b});
    sh  = sum >>> s;
    return sh[W-1:0];
  endfunction

  assign result = add_shift(data, bias, shift);

endmodule

// File: rtl/round_stage.sv
module round_stage
  import rnd_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [IN_W-1:0]          in_data,
  input  logic [$clog2(IN_W)-1:0]  in_shift,
  input  logic [2:0]               in_mode,
  input  logic [IN_W-1:0]          dyn_bias,
  input  logic [LFSR_W-1:0]        lfsr_seed,
  output logic                     out_valid,
  output logic [IN_W-1:0]          out_data
);

  localparam int SH_W = $clog2(IN_W);

  logic [LFSR_W-1:0] lfsr_state;
  logic [IN_W-1:0]   rnd_wide;
  logic [IN_W-1:0]   bias_w;
  logic [IN_W-1:0]   rounded_w;
  logic              tie_w;

  rnd_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .seed  (lfsr_seed),
    .step  (in_valid),
    .state (lfsr_state)
  );

  generate
    if (IN_W >= LFSR_W) begin : g_pad
      assign rnd_wide = {{(IN_W-LFSR_W){1'b0}}, lfsr_state};
    end else begin : g_cut
      assign rnd_wide = lfsr_state[IN_W-1:0];
    end
  endgenerate

  rnd_bias #(.W(IN_W), .SW(SH_W)) u_bias (
    .data  (in_data),
    .shift (in_shift),
    .mode  (in_mode),
    .dyn   (dyn_bias),
    .rnd   (rnd_wide),
    .bias  (bias_w),
    .tie   (tie_w)
  );

  rnd_sum #(.W(IN_W), .SW(SH_W)) u_sum (
    .data   (in_data),
    .bias   (bias_w),
    .shift  (in_shift),
    .result (rounded_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= rounded_w;
    end
  end

  // R1: result appears one cycle after a valid sample
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1: idle cycles leave the output untouched
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));

  // R3: a non-negative value never rounds to a negative result toward zero
  assert_zero_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == RM_ZERO && !in_data[IN_W-1]) |=> !out_data[IN_W-1]);

  // R5: exact ties land on an even result
  assert_even_tie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == RM_EVEN && tie_w) |=> !out_data[0]);

  // R8: no discarded bits means pass-through
  assert_shift0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shift == '0) |=> (out_data == $past(in_data)));

endmodule

// File: tb/sim_round_stage.sv
`timescale 1ns/1ps
module sim_round_stage;

  localparam int W = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [SW-1:0] in_shift = '0;
  logic [2:0]    in_mode = '0;
  logic [W-1:0]  dyn_bias = '0;
  logic [15:0]   lfsr_seed = 16'hACE1;
  logic          out_valid;
  logic [W-1:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] ref_lf;

  always #4 clk = ~clk;

  round_stage #(.IN_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_shift(in_shift), .in_mode(in_mode), .dyn_bias(dyn_bias),
    .lfsr_seed(lfsr_seed), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [15:0] ref_step(input logic [15:0] st);
    return {st[0], st[15:1]} ^ ({16{st[0]}} & 16'h3400);
  endfunction

  function automatic int ref_round(input int x, input int s, input int m,
                                   input int dyn, input int rnd);
    int fl, rem, half, scale, c;
    scale = 1 << s;
    fl    = x >>> s;
    rem   = x - fl * scale;
    half  = scale / 2;
    if (s == 0) return x;
    case (m)
      0: return (x < 0 && rem != 0) ? fl + 1 : fl;
      1: begin
        if (rem > half) return fl + 1;
        if (rem == half) return (x >= 0) ? fl + 1 : fl;
        return fl;
      end
      4: begin
        if (rem > half) return fl + 1;
        if (rem == half) return (fl % 2 == 0) ? fl : fl + 1;
        return fl;
      end
      2: begin c = dyn % scale; return (rem + c >= scale) ? fl + 1 : fl; end
      3: begin c = rnd % scale; return (rem + c >= scale) ? fl + 1 : fl; end
      default: return fl;
    endcase
  endfunction

  function automatic string tag_of(input int s, input int m);
    if (s == 0) return "R8";
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      3: return "R7";
      4: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int x, input int s, input int m, input int dyn);
    int exp;
    int act;
    exp = ref_round(x, s, m, dyn, int'(ref_lf));
    in_valid = 1'b1;
    in_data  = x[W-1:0];
    in_shift = s[SW-1:0];
    in_mode  = m[2:0];
    dyn_bias = dyn[W-1:0];
    @(posedge clk); #1;
    ref_lf = ref_step(ref_lf);
    act = int'($signed(out_data));
    check(out_valid === 1'b1, "R1", int'(out_valid), 1);
    check(act == exp, tag_of(s, m), act, exp);
  endtask

  task automatic reset_dut(input logic [15:0] seed);
    in_valid  = 1'b0;
    lfsr_seed = seed;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n  = 1'b1;
    ref_lf = (seed == 16'h0) ? 16'h1 : seed;
  endtask

  initial begin
    int keep;
    reset_dut(16'hACE1);
    // R2: reset state
    check(out_valid === 1'b0, "R2", int'(out_valid), 0);
    check(out_data === '0, "R2", int'(out_data), 0);

    // R3 R4 R5 R6 R7 R8: exhaustive sweep, all values and shifts
    for (int m = 0; m <= 4; m++)
      for (int s = 0; s < W; s++)
        for (int x = -128; x < 128; x++)
          send(x, s, m, (x * 7 + s * 13 + m) & 255);

    // R9: reserved codes floor
    for (int m = 5; m <= 7; m++)
      for (int s = 0; s < W; s++)
        for (int x = -128; x < 128; x++)
          send(x, s, m, 255);

    // R1: idle cycles hold the result; LFSR must not advance
    keep = int'(out_data);
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b0;
      in_data  = W'(k * 37 + 5);
      in_mode  = 3'd3;
      @(posedge clk); #1;
      check(out_valid === 1'b0, "R1", int'(out_valid), 0);
      check(int'(out_data) == keep, "R1", int'(out_data), keep);
    end
    // R7: LFSR state after idle cycles still matches reference
    for (int x = -128; x < 128; x += 3) send(x, 7, 3, 0);

    // R7: zero seed is replaced by 1
    reset_dut(16'h0000);
    check(out_valid === 1'b0, "R2", int'(out_valid), 0);
    for (int x = -128; x < 128; x++) send(x, 6, 3, 0);
    for (int x = -128; x < 128; x += 5) send(x, 4, 3, 0);

    in_valid = 1'b0;
    @(posedge clk); #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule